// File: doc/BRIEF.md
# Read-Add-Write Burst Master

This block is a bus master that carries out one fixed operation each time it is started. It fetches four consecutive data words from a base address with a single incrementing read burst. It adds the value 2 to every byte of those words, with each byte wrapping on its own. It then stores the four results back at the same addresses with an incrementing write burst. When the write response comes back, the block hands the bus back by pulsing a release output toward the interconnect that arbitrates among masters.

The master drives the read address, read data, write address, write data and write response channels. Every VALID it drives goes high without waiting for READY and stays high, with its payload unchanged, until the handshake completes. A data beat that the slave refuses is offered again unchanged. The write response code is latched for the user. Anomalies in the read data are gathered into a single fault flag: a missing or early last-beat marker, an error read response, or an unexpected transaction ID.

Top module: `rmw_burst_master`

## Requirements
- R1: A start pulse while idle raises arValid on the next cycle with arAddr equal to the sampled base address, arLen = 3 (four beats), arBurst = 2'b01 (incrementing), arSize = 3'd2 (4-byte beats) and arId = the transaction ID (default 1).
- R2: Once arValid, awValid or wValid is high it stays high, with its address or data unchanged, until the matching READY is seen at a clock edge.
- R3: rReady is high for the whole read data phase. The four accepted read beats are stored in arrival order.
- R4: Each outgoing write beat equals the matching read beat with 2 added to every byte modulo 256, and no carry passes between bytes (0xFF becomes 0x01).
- R5: The write address is issued only after the fourth read beat is accepted. It uses the same base address with awLen = 3, awBurst = 2'b01 and awSize = 3'd2.
- R6: wValid stays low until the write address handshake has completed.
- R7: wLast is high only on the fourth write beat, and wStrb is all ones on every beat.
- R8: While wReady is low, the pending beat is held and is not counted as sent.
- R9: bReady is high while the master waits for the write response. The bResp code is latched onto respStatus when the response arrives.
- R10: busRelease pulses for exactly one cycle, in the cycle after the write response handshake. done rises in that same cycle and stays high until the next start.
- R11: xferFault is set if rLast differs from "this is the fourth beat" on any accepted read beat, if rResp is not 2'b00, or if rId/bId differs from the transaction ID. It is cleared by start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operation (honoured only while idle) |
| baseAddr | input | ADDR_W | Byte address of the first word |
| done | output | 1 | Operation complete; high until next start |
| busRelease | output | 1 | One-cycle pulse handing the bus back |
| respStatus | output | 2 | Latched write response code |
| xferFault | output | 1 | Read-side anomaly flag |
| arId | output | ID_W | Read address ID |
| arAddr | output | ADDR_W | Read burst start address |
| arLen | output | 8 | Read beats minus one |
| arSize | output | 3 | Log2 of bytes per beat |
| arBurst | output | 2 | Read burst type |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rId | input | ID_W | Read data ID |
| rData | input | DATA_W | Read data |
| rResp | input | 2 | Read response |
| rLast | input | 1 | Last read beat marker |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| awId | output | ID_W | Write address ID |
| awAddr | output | ADDR_W | Write burst start address |
| awLen | output | 8 | Write beats minus one |
| awSize | output | 3 | Log2 of bytes per beat |
| awBurst | output | 2 | Write burst type |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| wData | output | DATA_W | Write data |
| wStrb | output | DATA_W/8 | Write byte strobes |
| wLast | output | 1 | Last write beat marker |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| bId | input | ID_W | Write response ID |
| bResp | input | 2 | Write response code |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |

## Verification
arValid is due one clock after start is sampled. awValid is due one clock after the edge that takes the fourth read beat, wValid one clock after the write address handshake, and bReady one clock after the edge that takes the last write beat. busRelease, done, respStatus and xferFault all settle one clock after the response handshake. The bench changes inputs and samples outputs only on falling edges, so every value it reads is the settled value for the next rising edge. It decides whether a handshake happens from the READY it has just driven together with the VALID it observes in that same half-cycle, and compares each write beat against a value it computes from its own memory model.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_WR_RESP,
    ST_FINISH
  } rmwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;   // new operation: capture base, clear counters and flags
    logic capBeat;    // accept one read beat
    logic sendBeat;   // one write beat accepted
    logic latchResp;  // write response accepted
  } ctlStrobes_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        arReady,
  input  logic        rValid,
  input  logic        awReady,
  input  logic        wReady,
  input  logic        bValid,
  input  logic        rdLast,
  input  logic        wrLast,
  output ctlStrobes_t stb,
  output logic        arValid,
  output logic        rReady,
  output logic        awValid,
  output logic        wValid,
  output logic        bReady,
  output logic        busRelease
);

  rmwState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (start) nextState = ST_RD_ADDR;
      ST_RD_ADDR: if (arReady) nextState = ST_RD_DATA;
      ST_RD_DATA: if (rValid && rdLast) nextState = ST_WR_ADDR;
      ST_WR_ADDR: if (awReady) nextState = ST_WR_DATA;
      ST_WR_DATA: if (wReady && wrLast) nextState = ST_WR_RESP;
      ST_WR_RESP: if (bValid) nextState = ST_FINISH;
      ST_FINISH:  nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign arValid    = (state == ST_RD_ADDR);
  assign rReady     = (state == ST_RD_DATA);
  assign awValid    = (state == ST_WR_ADDR);
  assign wValid     = (state == ST_WR_DATA);
  assign bReady     = (state == ST_WR_RESP);
  assign busRelease = (state == ST_FINISH);

  assign stb.loadBase  = (state == ST_IDLE) && start;
  assign stb.capBeat   = rReady && rValid;
  assign stb.sendBeat  = wValid && wReady;
  assign stb.latchResp = bReady && bValid;

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int BEATS   = 4,
  parameter int ADD_VAL = 2,
  parameter logic [ID_W-1:0] TXN_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ID_W-1:0]   rId,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bResp,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] wData,
  output logic              rdLast,
  output logic              wrLast,
  output logic              done,
  output logic [1:0]        respStatus,
  output logic              xferFault
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);
  localparam logic [7:0] ADD_BYTE = 8'(ADD_VAL);

  logic [DATA_W-1:0] beatBuf [BEATS];
  logic [CNT_W-1:0]  rdCnt, wrCnt;
  logic              rdAnomaly;

  assign rdLast    = (rdCnt == LAST_IDX);
  assign wrLast    = (wrCnt == LAST_IDX);
  assign rdAnomaly = (rLast != rdLast) || (rResp != 2'b00) || (rId != TXN_ID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr     <= '0;
      rdCnt      <= '0;
      wrCnt      <= '0;
      done       <= 1'b0;
      respStatus <= 2'b00;
      xferFault  <= 1'b0;
    end else begin
      if (stb.loadBase) begin
        opAddr    <= baseAddr;
        rdCnt     <= '0;
        wrCnt     <= '0;
        done      <= 1'b0;
        xferFault <= 1'b0;
      end
      if (stb.capBeat) begin
        rdCnt <= rdCnt + 1'b1;
        if (rdAnomaly) xferFault <= 1'b1;
      end
      if (stb.sendBeat) wrCnt <= wrCnt + 1'b1;
      if (stb.latchResp) begin
        respStatus <= bResp;
        done       <= 1'b1;
        if (bId != TXN_ID) xferFault <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : gBuf
    always_ff @(posedge clk) begin
      if (!rstN) beatBuf[b] <= '0;
      else if (stb.capBeat && rdCnt == CNT_W'(b)) beatBuf[b] <= rData;
    end
  end

  // per-byte add, each lane wraps on its own
  for (genvar k = 0; k < NBYTES; k++) begin : gLane
    assign wData[k*8 +: 8] = beatBuf[wrCnt][k*8 +: 8] + ADD_BYTE;
  end

endmodule

// File: rtl/rmw_burst_master.sv
module rmw_burst_master
  import rmw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int BEATS   = 4,
  parameter int ADD_VAL = 2,
  parameter logic [ID_W-1:0] TXN_ID = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   baseAddr,
  output logic                done,
  output logic                busRelease,
  output logic [1:0]          respStatus,
  output logic                xferFault,
  output logic [ID_W-1:0]     arId,
  output logic [ADDR_W-1:0]   arAddr,
  output logic [7:0]          arLen,
  output logic [2:0]          arSize,
  output logic [1:0]          arBurst,
  output logic                arValid,
  input  logic                arReady,
  input  logic [ID_W-1:0]     rId,
  input  logic [DATA_W-1:0]   rData,
  input  logic [1:0]          rResp,
  input  logic                rLast,
  input  logic                rValid,
  output logic                rReady,
  output logic [ID_W-1:0]     awId,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic [1:0]          awBurst,
  output logic                awValid,
  input  logic                awReady,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic                wLast,
  output logic                wValid,
  input  logic                wReady,
  input  logic [ID_W-1:0]     bId,
  input  logic [1:0]          bResp,
  input  logic                bValid,
  output logic                bReady
);

  localparam logic [7:0] LEN_CODE  = 8'(BEATS - 1);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  ctlStrobes_t       stb;
  logic              rdLast, wrLast;
  logic [ADDR_W-1:0] opAddr;

  rmw_ctrl u_ctrl (
    .clk, .rstN, .start, .arReady, .rValid, .awReady, .wReady, .bValid,
    .rdLast, .wrLast, .stb, .arValid, .rReady, .awValid, .wValid, .bReady,
    .busRelease
  );

  rmw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .BEATS(BEATS),
    .ADD_VAL(ADD_VAL), .TXN_ID(TXN_ID)
  ) u_dp (
    .clk, .rstN, .stb, .baseAddr, .rId, .rData, .rResp, .rLast, .bId, .bResp,
    .opAddr, .wData, .rdLast, .wrLast, .done, .respStatus, .xferFault
  );

  assign arId    = TXN_ID;
  assign arAddr  = opAddr;
  assign arLen   = LEN_CODE;
  assign arSize  = SIZE_CODE;
  assign arBurst = BURST_INCR;
  assign awId    = TXN_ID;
  assign awAddr  = opAddr;
  assign awLen   = LEN_CODE;
  assign awSize  = SIZE_CODE;
  assign awBurst = BURST_INCR;
  assign wStrb   = '1;
  assign wLast   = wValid && wrLast;

endmodule

// File: rtl/rmw_checker.sv
module rmw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              arValid,
  input logic              arReady,
  input logic [ADDR_W-1:0] arAddr,
  input logic [1:0]        arBurst,
  input logic [7:0]        arLen,
  input logic              rValid,
  input logic              rReady,
  input logic              awValid,
  input logic              awReady,
  input logic [ADDR_W-1:0] awAddr,
  input logic              wValid,
  input logic              wReady,
  input logic              wLast,
  input logic [DATA_W-1:0] wData,
  input logic              bValid,
  input logic              bReady,
  input logic              busRelease,
  input logic              done
);

  localparam int CW = $clog2(BEATS + 1) + 1;

  logic          awSeen;
  logic [CW-1:0] rdSeen, wrSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awSeen <= 1'b0;
      rdSeen <= '0;
      wrSeen <= '0;
    end else if (busRelease) begin
      awSeen <= 1'b0;
      rdSeen <= '0;
      wrSeen <= '0;
    end else begin
      if (awValid && awReady) awSeen <= 1'b1;
      if (rValid && rReady)   rdSeen <= rdSeen + 1'b1;
      if (wValid && wReady)   wrSeen <= wrSeen + 1'b1;
    end
  end

  assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr));

  assert_w_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData) && $stable(wLast));

  assert_ar_shape_R1: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> arBurst == 2'b01 && arLen == 8'(BEATS - 1));

  assert_aw_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> rdSeen == CW'(BEATS) && awAddr == arAddr);

  assert_w_after_aw_R6: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> awSeen);

  assert_wlast_pos_R7: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> (wLast == (wrSeen == CW'(BEATS - 1))));

  assert_release_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |=> !busRelease);

  assert_release_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    bValid && bReady |=> busRelease && done);

endmodule

bind rmw_burst_master rmw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)
) u_chk (
  .clk, .rstN, .arValid, .arReady, .arAddr, .arBurst, .arLen, .rValid, .rReady,
  .awValid, .awReady, .awAddr, .wValid, .wReady, .wLast, .wData, .bValid,
  .bReady, .busRelease, .done
);

// File: tb/sim_rmw_burst_master.sv
`timescale 1ns/1ps
module sim_rmw_burst_master;

  localparam int AW = 32, DW = 32, IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic done, busRelease, xferFault;
  logic [1:0] respStatus;
  logic [IW-1:0] arId, awId;
  logic [AW-1:0] arAddr, awAddr;
  logic [7:0] arLen, awLen;
  logic [2:0] arSize, awSize;
  logic [1:0] arBurst, awBurst;
  logic arValid, awValid, rReady, wValid, wLast, bReady;
  logic arReady = 0, awReady = 0, wReady = 0, rValid = 0, rLast = 0, bValid = 0;
  logic [IW-1:0] rId = 4'd1, bId = 4'd1;
  logic [DW-1:0] rData = '0;
  logic [1:0] rResp = 2'b00, bResp = 2'b00;
  logic [DW-1:0] wData;
  logic [DW/8-1:0] wStrb;

  int nTests = 0, nFail = 0;
  logic [31:0] mem [8];

  always #4 clk = ~clk;

  rmw_burst_master u0 (
    .clk, .rstN, .start, .baseAddr, .done, .busRelease, .respStatus, .xferFault,
    .arId, .arAddr, .arLen, .arSize, .arBurst, .arValid, .arReady,
    .rId, .rData, .rResp, .rLast, .rValid, .rReady,
    .awId, .awAddr, .awLen, .awSize, .awBurst, .awValid, .awReady,
    .wData, .wStrb, .wLast, .wValid, .wReady,
    .bId, .bResp, .bValid, .bReady
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] plus2(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = (v[i*8 +: 8] + 8'd2) & 8'hFF;
    return r;
  endfunction

  // one full operation with a bench-side slave
  task automatic runTxn(input logic [31:0] base, input int arDelay, input bit wStall,
                        input logic [1:0] resp, input bit badLast, input bit expFault);
    int idx = base / 4;
    logic [31:0] expW [4];
    int n;
    @(negedge clk); baseAddr = base; start = 1;
    @(negedge clk); start = 0;
    chk(arValid == 1 && arAddr == base, "R1 arValid/arAddr", {arValid, arAddr}, {1'b1, base});
    chk(arLen == 8'd3 && arBurst == 2'b01 && arSize == 3'd2 && arId == 4'd1,
        "R1 burst fields", {arLen, arBurst, arSize}, {8'd3, 2'b01, 3'd2});
    chk(done == 0, "R10 done cleared by start", done, 0);
    for (int d = 0; d < arDelay; d++) begin
      @(negedge clk);
      chk(arValid == 1 && arAddr == base, "R2 ar held", arAddr, base);
    end
    arReady = 1;
    @(negedge clk); arReady = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 1) begin
        rValid = 0;
        @(negedge clk);
        chk(rReady == 1, "R3 rReady during gap", rReady, 1);
      end
      chk(rReady == 1, "R3 rReady high", rReady, 1);
      chk(awValid == 0, "R5 no aw before last read", awValid, 0);
      rValid = 1; rData = mem[idx + i];
      rLast = (i == 3) ? !badLast : 1'b0;
      expW[i] = plus2(mem[idx + i]);
      @(negedge clk);
    end
    rValid = 0; rLast = 0;
    chk(awValid == 1 && awAddr == base, "R5 aw address", awAddr, base);
    chk(awLen == 8'd3 && awBurst == 2'b01 && awSize == 3'd2, "R5 aw fields", awLen, 3);
    chk(wValid == 0, "R6 no w before aw handshake", wValid, 0);
    @(negedge clk);
    chk(awValid == 1 && wValid == 0, "R6 w waits for aw", wValid, 0);
    awReady = 1;
    @(negedge clk); awReady = 0;
    n = 0;
    for (int k = 0; k < 40 && n < 4; k++) begin
      wReady = wStall ? k[0] : 1'b1;
      chk(wValid == 1, "R8 wValid held", wValid, 1);
      chk(wData == expW[n], "R4 write data", wData, expW[n]);
      chk(wLast == (n == 3), "R7 wLast position", wLast, n == 3);
      chk(wStrb == 4'hF, "R7 strobes", wStrb, 4'hF);
      if (wValid && wReady) begin mem[idx + n] = wData; n++; end
      @(negedge clk);
    end
    wReady = 0;
    chk(bReady == 1 && wValid == 0, "R9 bReady waiting", bReady, 1);
    chk(busRelease == 0, "R10 no early release", busRelease, 0);
    bValid = 1; bResp = resp;
    @(negedge clk); bValid = 0; bResp = 2'b00;
    chk(busRelease == 1, "R10 release pulse", busRelease, 1);
    chk(done == 1, "R10 done", done, 1);
    chk(respStatus == resp, "R9 bResp latched", respStatus, resp);
    chk(xferFault == expFault, "R11 fault flag", xferFault, expFault);
    @(negedge clk);
    chk(busRelease == 0 && done == 1, "R10 pulse one cycle, done held", {busRelease, done}, 2'b01);
    chk(arValid == 0, "R1 idle after release", arValid, 0);
  endtask

  task automatic testReset;
    chk(arValid == 0 && awValid == 0 && wValid == 0, "R1 reset valids low",
        {arValid, awValid, wValid}, 0);
    chk(done == 0 && busRelease == 0 && xferFault == 0 && respStatus == 0,
        "R10 reset status", {done, busRelease, xferFault, respStatus}, 0);
  endtask

  task automatic testPlain;     runTxn(32'h0, 0, 0, 2'b00, 0, 0); endtask
  task automatic testStallWrap; runTxn(32'h10, 3, 1, 2'b10, 0, 0); endtask
  task automatic testBadLast;   runTxn(32'h0, 1, 0, 2'b00, 1, 1); endtask

  initial begin
    mem[0] = 32'h02050403; mem[1] = 32'h11223344;
    mem[2] = 32'hA0B0C0D0; mem[3] = 32'h00000000;
    mem[4] = 32'hFFFFFFFF; mem[5] = 32'hFE01FF80;
    mem[6] = 32'h7F7F7F7F; mem[7] = 32'h12FF34FE;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testPlain();
    testStallWrap();
    chk(mem[4] == 32'h01010101, "R4 byte wrap no carry", mem[4], 32'h01010101);
    testBadLast();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule